// File: doc/BRIEF.md
# Serial Binary-to-Decimal Digit Converter

This block takes an unsigned binary number and produces its decimal digits one at a time, most significant first. A single-cycle start pulse captures the number and begins a conversion. Each digit is found by subtracting the decade weight from a working register once per cycle and counting how many subtractions fit. The last digit is simply what remains in the working register.

Every digit is presented on a 4-bit output together with a strobe that is high for exactly one cycle. Between strobes the digit output holds its last value. A completion flag rises with the strobe of the final digit. It stays high until the next start pulse or a reset. A start pulse always wins: one cycle later all three outputs read zero. A start pulse that arrives during a conversion abandons that conversion and begins a new one with the new number.

Top module: `bin_dec_serializer`

## Requirements
- R1: The number on `value_i` is captured on the clock edge where `start_i` is high. Later changes to `value_i` have no effect on the digits of that conversion.
- R2: In the cycle after `start_i` is sampled high, `digit_o` is 0, `digit_stb_o` is 0 and `done_o` is 0.
- R3: `digit_stb_o` is never high in two consecutive cycles.
- R4: Outside reset, and when the previous cycle held no start pulse, `digit_o` keeps its previous value in every cycle where `digit_stb_o` is low.
- R5: An 8-bit conversion yields exactly three strobed digits, in the order hundreds, tens, units. Each digit is a plain binary value from 0 to 9 on `digit_o[3:0]`.
- R6: `done_o` is low until the third digit is strobed, and it rises in the same cycle as that strobe.
- R7: Once high, `done_o` stays high, with no further strobes and `digit_o` unchanged, until the next start pulse or reset.
- R8: A start pulse during a conversion aborts it. Only the digits of the new number are produced afterwards.
- R9: While `rst` is high, and in the first cycle after it, all outputs are 0. A reset in the middle of a conversion stops it, and no further strobes follow.
- R10: For 8-bit input, the final strobe appears no later than 16 cycles after the start pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse: capture `value_i` and convert |
| value_i | input | VAL_W (8) | Unsigned number to convert |
| digit_o | output | DIG_W (4) | Current decimal digit, held between strobes |
| digit_stb_o | output | 1 | One-cycle marker for a new digit on `digit_o` |
| done_o | output | 1 | All digits of the number have been emitted |

## Verification
A corrupted working register or subtraction count shows up directly at the ports. The affected digit is out of range or disagrees with the arithmetic value, and this is visible at the strobe of that digit, at most about ten cycles after the fault. A wrong digit index or state shows up as a missing, extra or reordered strobe, or as `done_o` rising early or late. It is detectable no later than the strobe that should have been final. A broken strobe gate shows up as a strobe lasting two cycles, visible in the very next cycle.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bdc_state_e;

  // 10 raised to n, for small n
  function automatic int pow10(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  // number of decimal digits needed for the largest value of w bits
  function automatic int dec_digits(input int w);
    int m;
    int d;
    m = (w >= 31) ? 32'h7fffffff : ((1 << w) - 1);
    d = 0;
    while (m > 0) begin
      m = m / 10;
      d = d + 1;
    end
    return (d < 1) ? 1 : d;
  endfunction

endpackage

// File: rtl/bdc_weight_sel.sv
module bdc_weight_sel #(
  parameter int VAL_W   = 8,
  parameter int NUM_DIG = 3,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [VAL_W-1:0] weight_o
);
  import bdc_pkg::*;

  localparam int TBL_N = 1 << IDX_W;

  logic [VAL_W-1:0] tbl [TBL_N];

  // index 0 selects the most significant decade
  for (genvar g = 0; g < TBL_N; g++) begin : g_w
    if (g < NUM_DIG) begin : g_real
      assign tbl[g] = VAL_W'(pow10(NUM_DIG - 1 - g));
    end else begin : g_pad
      assign tbl[g] = VAL_W'(1);
    end
  end

  assign weight_o = tbl[idx_i];

endmodule

// File: rtl/bdc_step.sv
module bdc_step #(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] work_i,
  input  logic [VAL_W-1:0] weight_i,
  output logic             can_sub_o,
  output logic [VAL_W-1:0] work_sub_o
);
  always_comb begin
    can_sub_o  = (work_i >= weight_i);
    work_sub_o = work_i - weight_i;
  end
endmodule

// File: rtl/bdc_out_reg.sv
module bdc_out_reg #(
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             emit_i,
  input  logic             emit_last_i,
  input  logic [DIG_W-1:0] emit_digit_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             digit_stb_o,
  output logic             done_o
);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      digit_o     <= '0;
      digit_stb_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      digit_stb_o <= emit_i;
      if (emit_i) begin
        digit_o <= emit_digit_i;
        if (emit_last_i) done_o <= 1'b1;
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_clear_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (digit_o == '0 && !digit_stb_o && !done_o));

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    digit_stb_o |=> !digit_stb_o);

  p_digit_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(clear_i) && !digit_stb_o) |-> $stable(digit_o));

  p_digit_range_r5: assert property (@(posedge clk) disable iff (rst)
    digit_stb_o |-> (digit_o <= DIG_W'(9)));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clear_i) |=> (done_o && !digit_stb_o));

endmodule

// File: rtl/bin_dec_serializer.sv
module bin_dec_serializer #(
  parameter int VAL_W = 8,
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [VAL_W-1:0] value_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             digit_stb_o,
  output logic             done_o
);
  import bdc_pkg::*;

  localparam int NUM_DIG = dec_digits(VAL_W);
  localparam int IDX_W   = (NUM_DIG > 1) ? $clog2(NUM_DIG) : 1;
  localparam int LAST    = NUM_DIG - 1;
  localparam int MAX_LAT = 11 * NUM_DIG;
  localparam int LAT_W   = $clog2(MAX_LAT + 2);

  bdc_state_e       state_q;
  logic [VAL_W-1:0] work_q;
  logic [DIG_W-1:0] count_q;
  logic [IDX_W-1:0] idx_q;

  logic [VAL_W-1:0] weight;
  logic             can_sub;
  logic [VAL_W-1:0] work_sub;
  logic             is_last;
  logic             do_sub;
  logic             emit;
  logic [DIG_W-1:0] emit_digit;

  bdc_weight_sel #(.VAL_W(VAL_W), .NUM_DIG(NUM_DIG), .IDX_W(IDX_W)) u_wsel (
    .idx_i    (idx_q),
    .weight_o (weight)
  );

  bdc_step #(.VAL_W(VAL_W)) u_step (
    .work_i     (work_q),
    .weight_i   (weight),
    .can_sub_o  (can_sub),
    .work_sub_o (work_sub)
  );

  always_comb begin
    is_last    = (idx_q == IDX_W'(LAST));
    do_sub     = (state_q == ST_RUN) && !start_i && !is_last && can_sub;
    // a digit may leave only when the previous strobe has dropped
    emit       = (state_q == ST_RUN) && !start_i && !do_sub && !digit_stb_o;
    emit_digit = is_last ? work_q[DIG_W-1:0] : count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      count_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_RUN;
      work_q  <= value_i;
      count_q <= '0;
      idx_q   <= '0;
    end else if (do_sub) begin
      work_q  <= work_sub;
      count_q <= count_q + DIG_W'(1);
    end else if (emit) begin
      count_q <= '0;
      if (is_last) state_q <= ST_DONE;
      else         idx_q   <= idx_q + IDX_W'(1);
    end
  end

  bdc_out_reg #(.DIG_W(DIG_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (start_i),
    .emit_i       (emit),
    .emit_last_i  (is_last),
    .emit_digit_i (emit_digit),
    .digit_o      (digit_o),
    .digit_stb_o  (digit_stb_o),
    .done_o       (done_o)
  );

  // cycles spent converting since the last start
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst || start_i)            lat_q <= '0;
    else if (state_q == ST_RUN)    lat_q <= lat_q + LAT_W'(1);
  end

  p_no_early_done_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> !done_o);

  p_latency_bound_r10: assert property (@(posedge clk) disable iff (rst)
    lat_q <= LAT_W'(MAX_LAT));

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!digit_stb_o && !done_o && digit_o == '0));

endmodule

// File: tb/bin_dec_serializer_bench.sv
module bin_dec_serializer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] value_i = 8'd0;
  logic [3:0] digit_o;
  logic       digit_stb_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bin_dec_serializer u_bin_dec_serializer (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .value_i     (value_i),
    .digit_o     (digit_o),
    .digit_stb_o (digit_stb_o),
    .done_o      (done_o)
  );

  function automatic int exp_digit(input int v, input int pos);
    case (pos)
      0:       return v / 100;
      1:       return (v / 10) % 10;
      default: return v % 10;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // we are at a negedge: pulse start with v, return at next negedge
  task automatic pulse_start(input logic [7:0] v);
    value_i = v;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    value_i = 8'($urandom);  // R1: later input must not matter
  endtask

  task automatic convert_and_check(input logic [7:0] v);
    int got [3];
    int ndig;
    int cyc;
    bit prev_stb;
    logic [3:0] prev_dig;
    pulse_start(v);
    chk(digit_o == 4'd0, "R2 digit cleared", digit_o, 0);
    chk(!digit_stb_o, "R2 strobe cleared", digit_stb_o, 0);
    chk(!done_o, "R2 done cleared", done_o, 0);
    ndig = 0;
    cyc = 0;
    prev_stb = 1'b0;
    prev_dig = digit_o;
    while (ndig < 3 && cyc < 30) begin
      @(negedge clk);
      cyc++;
      if (digit_stb_o) begin
        chk(!prev_stb, "R3 strobe width", 2, 1);
        got[ndig] = int'(digit_o);
        ndig++;
        if (ndig < 3) chk(!done_o, "R6 done early", done_o, 0);
        else          chk(done_o, "R6 done with last digit", done_o, 1);
      end else begin
        chk(digit_o == prev_dig, "R4 digit held", digit_o, prev_dig);
        chk(!done_o, "R6 done without strobe", done_o, 0);
      end
      prev_stb = digit_stb_o;
      prev_dig = digit_o;
    end
    chk(ndig == 3, "R5 digit count", ndig, 3);
    chk(cyc <= 16, "R10 latency", cyc, 16);
    for (int i = 0; i < ndig; i++)
      chk(got[i] == exp_digit(int'(v), i), "R5 R1 digit value", got[i], exp_digit(int'(v), i));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done_o, "R7 done sticky", done_o, 1);
      chk(!digit_stb_o, "R7 no extra strobe", digit_stb_o, 0);
      chk(digit_o == prev_dig, "R7 digit frozen", digit_o, prev_dig);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(digit_o == 4'd0 && !digit_stb_o && !done_o, "R9 reset outputs", digit_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(digit_o == 4'd0 && !digit_stb_o && !done_o, "R9 after reset", done_o, 0);

    // directed corners
    convert_and_check(8'd0);
    convert_and_check(8'd255);
    convert_and_check(8'd99);
    convert_and_check(8'd100);
    convert_and_check(8'd9);
    convert_and_check(8'd190);
    convert_and_check(8'd10);

    // R8: abort mid-conversion at several points
    for (int k = 1; k <= 6; k++) begin
      pulse_start(8'd199);
      repeat (k - 1) @(negedge clk);
      convert_and_check(8'(37 + k));
    end

    // R9: reset in the middle of a conversion
    pulse_start(8'd250);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!digit_stb_o && !done_o && digit_o == 4'd0, "R9 mid-run reset", done_o, 0);
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(!digit_stb_o && !done_o, "R9 stays idle", digit_stb_o, 0);
    end

    // constrained random values
    for (int n = 0; n < 40; n++) convert_and_check(8'($urandom));

    finish_run();
  end

endmodule